// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates a two's complement number that streams through it one bit per clock, least significant bit first. The word length is not fixed. The block handles words of any length and has no word counter. Each output bit is produced in the same cycle as the input bit it belongs to, so the negated word leaves the block with zero cycles of latency.

Internally the block is a two-phase machine. In the pass phase, every bit is copied to the output. The first 1 that arrives is also copied, and it moves the machine to the invert phase. From then on, every bit is complemented. A strobe marks which cycles carry a data bit. An active-high synchronous reset ends the current word, and the first bit of the next word may arrive in the very next cycle.

Top module: `serial_negator`

## Requirements
- R1: One clock edge with `rst` high puts the block in the pass phase. The first valid bit that follows is returned unchanged on `ser_out`.
- R2: While no valid 1 has arrived since the last reset, `ser_out` equals `ser_in` in every cycle where `bit_valid` is high.
- R3: The first valid bit equal to 1 is itself output as 1. It moves the block into the invert phase, which takes effect for the following valid bit.
- R4: Once the block is in the invert phase, `ser_out` equals the complement of `ser_in` on every valid cycle until a reset.
- R5: A cycle with `bit_valid` low leaves the phase unchanged, whatever value `ser_in` has in that cycle.
- R6: `ser_out` is 0 in every cycle where `bit_valid` is low.
- R7: In a cycle where `rst` and `bit_valid` are both high, `ser_out` is computed from the phase the block held before that cycle. The next cycle starts in the pass phase.
- R8: For any word length n and word value w, the n output bits collected least significant bit first equal (2^n - w) mod 2^n. This includes the all-zero word and the most negative word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; ends the current word |
| bit_valid | input | 1 | High when `ser_in` carries a data bit |
| ser_in | input | 1 | Serial input bit, least significant bit first |
| ser_out | output | 1 | Negated serial bit, combinational in the same cycle |

## Verification
A reset and a data bit can arrive in the same cycle. When they do, the output of that cycle must still follow the old phase, while the next cycle must already be back in the pass phase. The bench provokes this by first pushing the block into the invert phase. It then drives a valid 1 together with `rst`, and expects a 0 in that cycle and a copied 1 in the cycle after. A full sweep of every word of length 1 to 8 then checks the arithmetic result. Part of that sweep inserts idle cycles between bits, which tests the hold behaviour against the same expected values.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;

    typedef enum logic {
        PH_PASS   = 1'b0,
        PH_INVERT = 1'b1
    } neg_phase_e;

    typedef struct packed {
        neg_phase_e phase;
    } neg_state_t;

    localparam neg_state_t NEG_STATE_INIT = '{phase: PH_PASS};

endpackage

// File: rtl/neg_phase_tracker.sv
module neg_phase_tracker
    import serial_negator_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       bit_in,
    output neg_phase_e phase_q
);

    neg_state_t state_d;
    neg_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (valid && bit_in) begin
            state_d.phase = PH_INVERT;
        end
        if (rst) begin
            state_d = NEG_STATE_INIT;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign phase_q = state_q.phase;

    // R3
    first_one_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && bit_in && phase_q == PH_PASS) |=> (phase_q == PH_INVERT));

    // R4
    invert_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_INVERT) |=> (phase_q == PH_INVERT));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid) |=> $stable(phase_q));

endmodule

// File: rtl/neg_output_stage.sv
module neg_output_stage
    import serial_negator_pkg::*;
(
    input  logic       valid,
    input  logic       bit_in,
    input  neg_phase_e phase,
    output logic       bit_out
);

    logic flip_d;

    always_comb begin
        flip_d  = (phase == PH_INVERT);
        bit_out = valid & (bit_in ^ flip_d);
    end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
    import serial_negator_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic ser_in,
    output logic ser_out
);

    neg_phase_e phase_q;

    neg_phase_tracker u_tracker (
        .clk     (clk),
        .rst     (rst),
        .valid   (bit_valid),
        .bit_in  (ser_in),
        .phase_q (phase_q)
    );

    neg_output_stage u_stage (
        .valid   (bit_valid),
        .bit_in  (ser_in),
        .phase   (phase_q),
        .bit_out (ser_out)
    );

    // R2
    pass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && phase_q == PH_PASS) |-> (ser_out == ser_in));

    // R4
    invert_out_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && phase_q == PH_INVERT) |-> (ser_out != ser_in));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid) |-> (ser_out == 1'b0));

endmodule

// File: tb/serial_negator_bench.sv
module serial_negator_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_negator u_serial_negator (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .ser_in    (ser_in),
        .ser_out   (ser_out)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    // drive one cycle at the falling edge, sample the output 2 ns later
    task automatic step(input logic r, input logic v, input logic d, output logic o);
        @(negedge clk);
        rst = r; bit_valid = v; ser_in = d;
        #2;
        o = ser_out;
    endtask

    task automatic run_word(input logic [63:0] w, input int n, input bit gaps,
                            output logic [63:0] got);
        logic o;
        got = '0;
        step(1'b1, 1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1, w[i], o);
            got[i] = o;
            if (gaps && (i % 2 == 0)) begin
                step(1'b0, 1'b0, 1'b1, o);
                check("R6 idle output", {63'b0, o}, 64'd0);
            end
        end
    endtask

    function automatic logic [63:0] negate(input logic [63:0] w, input int n);
        logic [63:0] mask;
        mask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        return (~w + 64'd1) & mask;
    endfunction

    initial begin
        logic o;
        logic [63:0] got;

        // R1: reset state, idle output and first bit copied
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        check("R1 idle after reset", {63'b0, o}, 64'd0);
        step(1'b0, 1'b1, 1'b1, o);
        check("R1 first bit copied", {63'b0, o}, 64'd1);

        // R2: zero bits pass unchanged
        run_word(64'h0, 8, 1'b0, got);
        check("R2 zero word", got, 64'h0);

        // R3 / R4: first 1 copied, later bits inverted
        run_word(64'h14, 8, 1'b0, got);
        check("R3 first one copied", {63'b0, got[2]}, 64'd1);
        check("R4 later bits inverted", got, 64'hEC);

        // R5: idle cycles with data 1 do not change phase
        run_word(64'h10, 8, 1'b1, got);
        check("R5 hold across idle", got, 64'hF0);

        // R7: reset and valid bit in the same cycle
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b1, 1'b1, o);
        step(1'b1, 1'b1, 1'b1, o);
        check("R7 output from old phase", {63'b0, o}, 64'd0);
        step(1'b0, 1'b1, 1'b1, o);
        check("R7 pass phase after reset", {63'b0, o}, 64'd1);
        step(1'b0, 1'b1, 1'b1, o);
        check("R7 invert resumes", {63'b0, o}, 64'd0);

        // R8: long corner words
        run_word(64'h0, 40, 1'b0, got);
        check("R8 long zero", got, 64'h0);
        run_word(64'h80_0000_0000, 40, 1'b0, got);
        check("R8 most negative", got, 64'h80_0000_0000);
        run_word(64'hFF_FFFF_FFFF, 40, 1'b0, got);
        check("R8 minus one", got, 64'h1);

        // R8: exhaustive sweep of lengths 1..8, gaps on odd words
        for (int n = 1; n <= 8; n++) begin
            for (int v = 0; v < (1 << n); v++) begin
                run_word(64'(v), n, (v % 2) == 1, got);
                check("R8 sweep", got, negate(64'(v), n));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule